// File: doc/BRIEF.md
# Cipher Block Pad Generator

This block completes the last cipher block of a message. Given the number of message bytes that sit in the final, partially filled block (the tail count) and a pad-control word, it produces the pad bytes that bring the message up to a block boundary. Pad bytes leave the block as whole blocks, each with a per-byte mask that marks which lanes hold pad, so a downstream merger can OR them into the tail of the data.

Four fill schemes are selectable: all-zero, a constant character, the length-valued scheme of PKCS#7, and an IPsec-style scheme with an incrementing count followed by a pad-length byte and a next-header byte. The last two schemes sometimes need a whole block beyond the partial one. Once the final pad block has gone out, a status beat reports the total number of pad bytes appended and how many whole extra blocks were added.

A request is a one-cycle `start` pulse while the block is idle. The block width is the parameter `BLK_BYTES` (default 8).

Top module: `pad_gen`

## Requirements
- R1: After reset, `busy`, `blk_valid` and `stat_valid` are 0.
- R2: Byte lane i of a pad block is `blk_data[8i+7:8i]` and lane order is message order. `blk_mask[i]` is 1 exactly on pad lanes. In the first block, pad starts at lane `tail_cnt` (lane 0 when `tail_cnt` is 0). Lanes that are not pad read 0. Every pad block has its top lane set in the mask.
- R3: Mode 2'b00 (`ctrl_word[1:0]`) fills with 0x00. With `tail_cnt` 0 it emits no block and reports a pad length of 0.
- R4: Mode 2'b11 fills every pad lane with the character in `ctrl_word[9:2]`. With `tail_cnt` 0 it emits no block.
- R5: Mode 2'b01 writes the number of pad bytes added into every pad byte. With `tail_cnt` 0 it emits one full block whose bytes all hold `BLK_BYTES`.
- R6: Mode 2'b10 fills with 1, 2, 3, … and then places two trailer bytes in the final two lanes. The first trailer byte is the count of incrementing bytes, which excludes the two trailer bytes. The second trailer byte is `ctrl_word[17:10]`.
- R7: In mode 2'b10, when `tail_cnt` is 0 the pad is one full extra block. When `tail_cnt` is `BLK_BYTES-1` the pad spans two blocks, and the second block is fully masked.
- R8: A `start` seen in idle at a clock edge puts the first pad block on the outputs in the following cycle. Further blocks follow on consecutive cycles, and `blk_last` marks the final block.
- R9: `stat_valid` is high for exactly one cycle. That cycle directly follows the last pad block, or directly follows the accepting edge when no block is needed. `stat_pad_len` gives the total pad bytes appended, trailer bytes included. `stat_extra_blks` gives the number of whole blocks beyond the partial one.
- R10: A `start` pulse while `busy` is 1 is ignored. It produces no extra blocks or status and does not alter the request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| tail_cnt | input | RW | Message bytes in the final partial block (0 means block-aligned) |
| ctrl_word | input | 18 | Mode [1:0], fill character [9:2], next-header [17:10] |
| busy | output | 1 | A request is in flight |
| blk_valid | output | 1 | Pad block on `blk_data` / `blk_mask` |
| blk_data | output | 8*BLK_BYTES | Pad block, lane 0 in the low byte |
| blk_mask | output | BLK_BYTES | Pad-lane mask |
| blk_last | output | 1 | Final pad block of the request |
| stat_valid | output | 1 | Status beat |
| stat_pad_len | output | RW+2 | Total pad bytes appended |
| stat_extra_blks | output | 2 | Whole extra blocks added |

## Verification
Every mode is driven across every tail count from 0 to `BLK_BYTES-1`. This separates the lane-start arithmetic, which tail count 0 versus nonzero exercises, from the per-mode byte values. The IPsec-style scheme is also tried at tail counts 6, 7 and 0. Those three values tell apart the case where the trailer exactly fills the block, the case where it spills into a second block, and the case of a fully fresh block. A zero-fill request at an aligned tail checks the path with no block at all. A second `start` sent while a request is still emitting checks that the block ignores it.

// File: rtl/padgen_pkg.sv
package padgen_pkg;

   typedef enum logic [1:0] {
      PAD_ZERO  = 2'b00,
      PAD_PKCS  = 2'b01,
      PAD_IPSEC = 2'b10,
      PAD_FIXED = 2'b11
   } pad_mode_e;

   typedef struct packed {
      logic [7:0] nxt_hdr;
      logic [7:0] fill_chr;
      pad_mode_e  mode;
   } pad_ctrl_t;

   localparam int CTRL_W = $bits(pad_ctrl_t);

endpackage

// File: rtl/pad_plan.sv
module pad_plan
   import padgen_pkg::*;
#(
   parameter int BLK_BYTES = 8,
   localparam int RW = $clog2(BLK_BYTES),
   localparam int LW = RW + 2
) (
   input  logic [RW-1:0] tail,
   input  pad_mode_e     mode,
   output logic [1:0]    n_blks,
   output logic [LW-1:0] pad_len,
   output logic [1:0]    extra_cnt
);

   localparam logic [LW-1:0] BLK_L  = LW'(BLK_BYTES);
   localparam logic [RW-1:0] TOP_TL = RW'(BLK_BYTES - 1);

   logic          partial;
   logic [LW-1:0] room;

   assign partial = |tail;
   assign room    = BLK_L - LW'(tail);

   always_comb begin
      n_blks  = 2'd1;
      pad_len = room;
      unique case (mode)
         PAD_ZERO, PAD_FIXED: begin
            n_blks  = partial ? 2'd1 : 2'd0;
            pad_len = partial ? room : '0;
         end
         PAD_PKCS: begin
            n_blks  = 2'd1;
            pad_len = room;
         end
         PAD_IPSEC: begin
            if (!partial) begin
               n_blks  = 2'd1;
               pad_len = BLK_L;
            end else if (tail == TOP_TL) begin
               n_blks  = 2'd2;
               pad_len = room + BLK_L;
            end else begin
               n_blks  = 2'd1;
               pad_len = room;
            end
         end
         default: ;
      endcase
   end

   assign extra_cnt = n_blks - {1'b0, partial};

endmodule

// File: rtl/pad_lanes.sv
module pad_lanes
   import padgen_pkg::*;
#(
   parameter int BLK_BYTES = 8,
   localparam int RW = $clog2(BLK_BYTES),
   localparam int LW = RW + 2,
   localparam int DW = 8 * BLK_BYTES
) (
   input  logic                 blk_idx,
   input  logic [RW-1:0]        tail,
   input  pad_ctrl_t            ctrl,
   input  logic [LW-1:0]        pad_len,
   output logic [DW-1:0]        data,
   output logic [BLK_BYTES-1:0] mask
);

   logic [LW-1:0] inc_cnt;
   assign inc_cnt = pad_len - LW'(2);

   for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
      logic [LW-1:0] pos;
      logic [LW-1:0] rel;
      logic [7:0]    val;

      assign pos = LW'({blk_idx, RW'(g)});
      assign rel = pos - LW'(tail);

      always_comb begin
         unique case (ctrl.mode)
            PAD_ZERO:  val = 8'h00;
            PAD_FIXED: val = ctrl.fill_chr;
            PAD_PKCS:  val = 8'(pad_len);
            PAD_IPSEC: begin
               if (rel < inc_cnt)       val = 8'(rel + LW'(1));
               else if (rel == inc_cnt) val = 8'(inc_cnt);
               else                     val = ctrl.nxt_hdr;
            end
            default:   val = 8'h00;
         endcase
      end

      assign mask[g]          = (pos >= LW'(tail));
      assign data[8*g +: 8]   = mask[g] ? val : 8'h00;
   end

endmodule

// File: rtl/pad_gen.sv
module pad_gen
   import padgen_pkg::*;
#(
   parameter int BLK_BYTES = 8,
   localparam int RW = $clog2(BLK_BYTES),
   localparam int LW = RW + 2,
   localparam int DW = 8 * BLK_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [RW-1:0]        tail_cnt,
   input  logic [17:0]          ctrl_word,
   output logic                 busy,
   output logic                 blk_valid,
   output logic [DW-1:0]        blk_data,
   output logic [BLK_BYTES-1:0] blk_mask,
   output logic                 blk_last,
   output logic                 stat_valid,
   output logic [LW-1:0]        stat_pad_len,
   output logic [1:0]           stat_extra_blks
);

   if (BLK_BYTES < 4 || BLK_BYTES > 32 || (BLK_BYTES & (BLK_BYTES - 1)) != 0) begin : g_bad_blk
      $error("pad_gen: BLK_BYTES must be a power of two from 4 to 32");
   end
   if (CTRL_W != 18) begin : g_bad_ctrl
      $error("pad_gen: control word layout must be 18 bits");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_STAT} seq_e;

   seq_e          st_q;
   logic [RW-1:0] tail_q;
   pad_ctrl_t     ctrl_q;
   pad_ctrl_t     ctrl_in;
   logic          idx_q;

   logic          idle;
   logic [RW-1:0] plan_tail;
   pad_mode_e     plan_mode;
   logic [1:0]    n_blks;
   logic [LW-1:0] pad_len;
   logic [1:0]    extra_cnt;
   logic          last_blk;
   logic [DW-1:0] lane_data;
   logic [BLK_BYTES-1:0] lane_mask;

   assign ctrl_in   = pad_ctrl_t'(ctrl_word);
   assign idle      = (st_q == ST_IDLE);
   assign plan_tail = idle ? tail_cnt : tail_q;
   assign plan_mode = idle ? ctrl_in.mode : ctrl_q.mode;

   pad_plan #(.BLK_BYTES(BLK_BYTES)) u_plan (
      .tail      (plan_tail),
      .mode      (plan_mode),
      .n_blks    (n_blks),
      .pad_len   (pad_len),
      .extra_cnt (extra_cnt)
   );

   pad_lanes #(.BLK_BYTES(BLK_BYTES)) u_lanes (
      .blk_idx (idx_q),
      .tail    (tail_q),
      .ctrl    (ctrl_q),
      .pad_len (pad_len),
      .data    (lane_data),
      .mask    (lane_mask)
   );

   assign last_blk = ({1'b0, idx_q} == (n_blks - 2'd1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         tail_q <= '0;
         ctrl_q <= '0;
         idx_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  tail_q <= tail_cnt;
                  ctrl_q <= ctrl_in;
                  idx_q  <= 1'b0;
                  st_q   <= (n_blks != 2'd0) ? ST_EMIT : ST_STAT;
               end
            end
            ST_EMIT: begin
               if (last_blk) st_q  <= ST_STAT;
               else          idx_q <= 1'b1;
            end
            ST_STAT: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy            = !idle;
   assign blk_valid       = (st_q == ST_EMIT);
   assign blk_last        = blk_valid && last_blk;
   assign blk_data        = blk_valid ? lane_data : '0;
   assign blk_mask        = blk_valid ? lane_mask : '0;
   assign stat_valid      = (st_q == ST_STAT);
   assign stat_pad_len    = stat_valid ? pad_len : '0;
   assign stat_extra_blks = stat_valid ? extra_cnt : 2'd0;

   // R2
   mask_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid |-> blk_mask[BLK_BYTES-1]);

   // R7
   later_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && $past(blk_valid)) |-> (&blk_mask));

   // R9
   stat_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> ($past(blk_last) || $past(start && !busy)));

   // R9
   extra_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && stat_extra_blks != 2'd0) |-> (stat_pad_len >= LW'(BLK_BYTES)));

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !stat_valid) |=> busy);

endmodule

// File: tb/pad_gen_tb.sv
`timescale 1ns/1ps
module pad_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  tail_cnt = '0;
   logic [17:0] ctrl_word = '0;
   logic        busy, blk_valid, blk_last, stat_valid;
   logic [63:0] blk_data;
   logic [7:0]  blk_mask;
   logic [4:0]  stat_pad_len;
   logic [1:0]  stat_extra_blks;

   always #2 clk = ~clk;

   pad_gen #(.BLK_BYTES(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tail_cnt(tail_cnt),
      .ctrl_word(ctrl_word), .busy(busy), .blk_valid(blk_valid),
      .blk_data(blk_data), .blk_mask(blk_mask), .blk_last(blk_last),
      .stat_valid(stat_valid), .stat_pad_len(stat_pad_len),
      .stat_extra_blks(stat_extra_blks)
   );

   typedef struct {
      logic [63:0] d;
      logic [7:0]  m;
      logic        l;
      string       tag;
   } blk_exp_t;

   typedef struct {
      int len;
      int extra;
      int nb;
   } stat_exp_t;

   blk_exp_t  bq[$];
   stat_exp_t sq[$];
   int n_tests = 0;
   int n_fail  = 0;
   logic prev_last = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %h exp %h", tag, what, act, exp);
      end
   endtask

   // monitor: pops expected items as the design produces results
   always @(negedge clk) begin
      if (rst_n) begin
         if (blk_valid) begin
            if (bq.size() == 0) begin
               chk(1'b0, "R8", "unexpected block", blk_data, 64'h0);
            end else begin
               blk_exp_t e;
               e = bq.pop_front();
               chk(blk_data == e.d, e.tag, "block data", blk_data, e.d);
               chk(blk_mask == e.m, "R2", "block mask", {56'h0, blk_mask}, {56'h0, e.m});
               chk(blk_last == e.l, "R8", "last flag", {63'h0, blk_last}, {63'h0, e.l});
            end
         end
         if (stat_valid) begin
            if (sq.size() == 0) begin
               chk(1'b0, "R10", "unexpected status", {59'h0, stat_pad_len}, 64'h0);
            end else begin
               stat_exp_t s;
               s = sq.pop_front();
               chk(stat_pad_len == 5'(s.len), "R9", "pad length",
                   {59'h0, stat_pad_len}, 64'(s.len));
               chk(stat_extra_blks == 2'(s.extra), "R9", "extra blocks",
                   {62'h0, stat_extra_blks}, 64'(s.extra));
               chk((s.nb == 0) || prev_last, "R9", "status follows last block",
                   {63'h0, prev_last}, 64'h1);
            end
         end
         prev_last = blk_valid && blk_last;
      end
   end

   // driver: builds the expected pad from the requirements, then drives
   task automatic run_pad(input int r, input int mode, input int fill, input int nh,
                          input bit poke_busy);
      int pb[$];
      int p;
      int lane;
      int nb;
      string tag;
      logic [63:0] d;
      logic [7:0]  m;
      blk_exp_t it;
      stat_exp_t st;
      case (mode)
         0: begin tag = "R3"; if (r != 0) repeat (8 - r) pb.push_back(0); end
         3: begin tag = "R4"; if (r != 0) repeat (8 - r) pb.push_back(fill); end
         1: begin tag = "R5"; p = (r == 0) ? 8 : 8 - r; repeat (p) pb.push_back(p); end
         default: begin
            tag = ((r == 0) || (r == 7)) ? "R7" : "R6";
            p = (8 - ((r + 2) % 8)) % 8;
            for (int k = 1; k <= p; k++) pb.push_back(k);
            pb.push_back(p);
            pb.push_back(nh);
         end
      endcase
      lane = r; d = '0; m = '0; nb = 0;
      foreach (pb[k]) begin
         d[lane*8 +: 8] = 8'(pb[k]);
         m[lane] = 1'b1;
         lane++;
         if (lane == 8) begin
            it.d = d; it.m = m; it.l = 1'b0; it.tag = tag;
            bq.push_back(it);
            nb++; lane = 0; d = '0; m = '0;
         end
      end
      if (nb > 0) bq[bq.size()-1].l = 1'b1;
      st.len = pb.size();
      st.extra = nb - ((r != 0 && nb > 0) ? 1 : 0);
      st.nb = nb;
      sq.push_back(st);

      @(negedge clk);
      start = 1'b1;
      tail_cnt = 3'(r);
      ctrl_word = {8'(nh), 8'(fill), 2'(mode)};
      @(negedge clk);
      // R8: first block (or status when no block) one cycle after the accepting edge
      chk(blk_valid == (nb > 0), "R8", "first block timing", {63'h0, blk_valid}, 64'(nb > 0));
      if (nb == 0)
         chk(stat_valid == 1'b1, "R9", "status with no block", {63'h0, stat_valid}, 64'h1);
      if (poke_busy) begin
         // R10: a second request while busy
         start = 1'b1;
         tail_cnt = 3'((r + 3) % 8);
         ctrl_word = {8'h3C, 8'h5A, 2'(3 - mode)};
         @(negedge clk);
      end
      start = 1'b0;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(bq.size() == 0 && sq.size() == 0, poke_busy ? "R10" : "R9", "outstanding items",
          64'(bq.size() + sq.size()), 64'h0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(!busy && !blk_valid && !stat_valid, "R1", "idle after reset",
          {61'h0, busy, blk_valid, stat_valid}, 64'h0);

      run_pad(3, 0, 0, 0, 1'b0);       // R3 zero fill
      run_pad(0, 0, 0, 0, 1'b0);       // R3 aligned: no block
      run_pad(5, 3, 8'hA5, 0, 1'b0);   // R4 fixed fill
      run_pad(0, 3, 8'hA5, 0, 1'b0);   // R4 aligned
      run_pad(3, 1, 0, 0, 1'b0);       // R5
      run_pad(0, 1, 0, 0, 1'b0);       // R5 full extra block
      run_pad(7, 1, 0, 0, 1'b0);       // R5 single byte
      run_pad(1, 2, 0, 8'h32, 1'b0);   // R6
      run_pad(6, 2, 0, 8'h04, 1'b0);   // R6 trailer fills block exactly
      run_pad(7, 2, 0, 8'h11, 1'b0);   // R7 spill into second block
      run_pad(0, 2, 0, 8'h29, 1'b0);   // R7 fresh block
      for (int md = 0; md < 4; md++)
         for (int r = 0; r < 8; r++)
            run_pad(r, md, 8'hC3, 8'h06, 1'b0);
      run_pad(7, 2, 0, 8'h33, 1'b1);   // R10 poke during two-block run
      run_pad(2, 1, 0, 0, 1'b1);       // R10 poke during one-block run

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule